// File: doc/BRIEF.md
# Flash Prefetch Accelerator

This unit sits between a processor's fetch port and a slow flash array that returns one 128-bit line per access. It keeps two line buffers. The prefetch buffer follows straight-line code. The branch-trail buffer keeps the line reached by the last non-sequential miss. Each line holds four 32-bit words, so one flash access can serve up to four requests. A flash access takes a programmable number of cycles. The processor side sees a simple one-outstanding request/response port.

A mode field decides whether buffered data may be returned. Mode 0 never uses it. Mode 1 uses it only for requests flagged as sequential. Mode 2 uses it whenever the word is present. Every write to the mode field empties both buffers. Software should clear the mode to 0 before it changes the wait count, then set the mode it wants. When a request touches the last word of a line, the unit fetches the next line into the prefetch buffer in the background.

Top module: `flash_accel`

## Requirements
- R1: After reset the mode is 0, the wait count is 0, both buffers are empty, `req_ready` is 1, and `rsp_valid` and `fl_rd` are 0.
- R2: In mode 0 every accepted request starts a flash fetch and responds T+1 cycles after acceptance, where T is the effective wait count. Mode encoding 3 behaves like mode 0. Mode 0 never starts a background fetch.
- R3: In mode 1 a request flagged sequential (`req_seq`=1) whose line is buffered is answered in the cycle after acceptance. A non-sequential request always fetches from flash, even if its line is buffered.
- R4: In mode 2 any request whose line is held in either buffer is answered in the cycle after acceptance, whatever its sequential flag.
- R5: A line is 128 bits. The word address splits into line tag `req_addr[15:2]` and word index `req_addr[1:0]`. The index selects bits `[32*i +: 32]` of the line.
- R6: A sequential miss fills the prefetch buffer and a non-sequential miss fills the branch-trail buffer. Each buffer keeps its line while the other is refilled.
- R7: In modes 1 and 2, accepting a request for word index 3 fetches line tag+1 into the prefetch buffer. On a hit this fetch starts at once; on a miss it starts after the demand fetch. A later request into that line hits.
- R8: `fl_rd` stays high for exactly T consecutive cycles per fetch, and `fl_line` holds steady during that time. T is the wait-count register value, and a value of 0 means 2^4-1 = 15.
- R9: Any write to the mode field invalidates both buffers, so the next request misses. A fetch already running when the write happens does not fill a buffer.
- R10: Only one request is outstanding at a time. `req_ready` is low while any fetch runs. Every `rsp_valid` pulse follows either an accepted hit or the completion of a demand fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode field (also flushes buffers) |
| mode_wdata | input | 2 | New mode: 0 off, 1 sequential-only, 2 full, 3 off |
| tim_we | input | 1 | Write strobe for the wait count |
| tim_wdata | input | 4 | New wait count in cycles (0 means 15) |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 16 | Word address of the request |
| req_seq | input | 1 | Request continues the previous address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word |
| fl_rd | output | 1 | Flash line read in progress |
| fl_line | output | 14 | Line tag being read from flash |
| fl_rdata | input | 128 | Line data from flash, sampled on the last wait cycle |

## Verification
The assertions watch every cycle for the following:
- each flash fetch lasts exactly the loaded wait count and never has zero length;
- the line address stays still while a read runs;
- mode 0 never answers in one cycle;
- a hit always answers on the next cycle;
- a flush leaves each buffer invalid.

Only the bench scenarios can show the rest:
- which buffer a miss fills;
- that the other buffer survives;
- that a background fetch turns the next line into a hit;
- that a mode write forces a miss;
- that the correct word of the line comes back.

The scoreboard checks each response for data and for the exact cycle it arrives in.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SEQ  = 2'd1,
        MODE_FULL = 2'd2,
        MODE_RSVD = 2'd3
    } acc_mode_e;

    typedef enum logic {
        DST_PF = 1'b0,
        DST_BT = 1'b1
    } fill_dst_e;

    localparam int N_BUF = 2;

    // zero in the timing field selects the longest wait
    function automatic int unsigned wait_cycles(int unsigned tim, int unsigned lim);
        return (tim == 0) ? lim : tim;
    endfunction

    function automatic logic buf_usable(acc_mode_e m, logic seq);
        case (m)
            MODE_SEQ:  return seq;
            MODE_FULL: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic mode_active(acc_mode_e m);
        return (m == MODE_SEQ) || (m == MODE_FULL);
    endfunction

endpackage

// File: rtl/fa_wait_ctr.sv
module fa_wait_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (start)          cnt_q <= len;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    // checker: length of each busy run
    logic [CNT_W-1:0] chk_len_q, chk_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_len_q <= '0;
            chk_run_q <= '0;
        end else if (start) begin
            chk_len_q <= len;
            chk_run_q <= '0;
        end else if (busy) begin
            chk_run_q <= chk_run_q + CNT_W'(1);
        end
    end

    p_run_len_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_run_q == chk_len_q - CNT_W'(1)));
    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> (len != '0));
endmodule

// File: rtl/fa_line_buf.sv
module fa_line_buf #(
    parameter int TAG_W  = 14,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line
);
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= 1'b0;
        end else if (wr_en) begin
            vld_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            line_q <= '0;
        end else if (wr_en && !flush) begin
            tag_q  <= wr_tag;
            line_q <= wr_line;
        end
    end

    assign lk_hit  = vld_q && (tag_q == lk_tag);
    assign lk_line = line_q;

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);
endmodule

// File: rtl/flash_accel.sv
module flash_accel
    import flash_accel_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WORD_W = 32,
    parameter int WPL    = 4,
    parameter int TIM_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_we,
    input  logic [1:0]              mode_wdata,
    input  logic                    tim_we,
    input  logic [TIM_W-1:0]        tim_wdata,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_seq,
    output logic                    rsp_valid,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    fl_rd,
    output logic [AW-$clog2(WPL)-1:0] fl_line,
    input  logic [WORD_W*WPL-1:0]   fl_rdata
);
    localparam int IDX_W   = $clog2(WPL);
    localparam int TAG_W   = AW - IDX_W;
    localparam int LINE_W  = WORD_W * WPL;
    localparam int TIM_MAX = (1 << TIM_W) - 1;

    // control registers
    acc_mode_e        mode_q;
    logic [TIM_W-1:0] tim_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            tim_q  <= '0;
        end else begin
            if (mode_we) mode_q <= acc_mode_e'(mode_wdata);
            if (tim_we)  tim_q  <= tim_wdata;
        end
    end
    logic flush;
    assign flush = mode_we;

    // request decode
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    assign req_tag = req_addr[AW-1:IDX_W];
    assign req_idx = req_addr[IDX_W-1:0];

    // buffers
    logic              fill_done;
    logic [N_BUF-1:0]  buf_hit, buf_wr;
    logic [LINE_W-1:0] buf_line [N_BUF];
    fill_dst_e         f_dst_q;
    logic [TAG_W-1:0]  f_tag_q;

    for (genvar b = 0; b < N_BUF; b++) begin : g_buf
        assign buf_wr[b] = fill_done && (int'(f_dst_q) == b);
        fa_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_en   (buf_wr[b]),
            .wr_tag  (f_tag_q),
            .wr_line (fl_rdata),
            .lk_tag  (req_tag),
            .lk_hit  (buf_hit[b]),
            .lk_line (buf_line[b])
        );
    end

    logic              hit_any, accept, pf_trig;
    logic [LINE_W-1:0] hit_line;
    assign hit_any  = (|buf_hit) && buf_usable(mode_q, req_seq);
    assign hit_line = buf_hit[int'(DST_PF)] ? buf_line[int'(DST_PF)] : buf_line[int'(DST_BT)];
    assign accept   = req_valid && req_ready;
    assign pf_trig  = mode_active(mode_q) && (req_idx == IDX_W'(WPL - 1));

    // fetch sequencing
    logic             busy, done;
    logic             f_dem_q, f_drop_q, pf_pend_q;
    logic [IDX_W-1:0] f_idx_q;
    logic [TAG_W-1:0] pf_tag_q;
    logic             start_dem, start_pf_hit, start_pf_chain, start;
    logic [TIM_W-1:0] wait_len;

    assign start_dem      = accept && !hit_any;
    assign start_pf_hit   = accept && hit_any && pf_trig;
    assign start_pf_chain = done && f_dem_q && pf_pend_q;
    assign start          = start_dem || start_pf_hit || start_pf_chain;
    assign wait_len       = TIM_W'(wait_cycles(int'(tim_q), TIM_MAX));
    assign fill_done      = done && !f_drop_q && mode_active(mode_q);

    fa_wait_ctr #(.CNT_W(TIM_W)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .len   (wait_len),
        .busy  (busy),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f_dem_q   <= 1'b0;
            f_drop_q  <= 1'b0;
            f_dst_q   <= DST_PF;
            f_idx_q   <= '0;
            f_tag_q   <= '0;
            pf_pend_q <= 1'b0;
            pf_tag_q  <= '0;
        end else begin
            if (start_dem) begin
                f_dem_q   <= 1'b1;
                f_drop_q  <= 1'b0;
                f_dst_q   <= req_seq ? DST_PF : DST_BT;
                f_idx_q   <= req_idx;
                f_tag_q   <= req_tag;
                pf_pend_q <= pf_trig;
                pf_tag_q  <= req_tag + TAG_W'(1);
            end else if (start_pf_hit || start_pf_chain) begin
                f_dem_q   <= 1'b0;
                f_drop_q  <= 1'b0;
                f_dst_q   <= DST_PF;
                f_tag_q   <= start_pf_hit ? req_tag + TAG_W'(1) : pf_tag_q;
                pf_pend_q <= 1'b0;
            end
            if (flush) begin
                f_drop_q  <= 1'b1;
                pf_pend_q <= 1'b0;
            end
        end
    end

    // response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (accept && hit_any) || (done && f_dem_q);
            if (accept && hit_any)
                rsp_data <= hit_line[req_idx*WORD_W +: WORD_W];
            else if (done && f_dem_q)
                rsp_data <= fl_rdata[f_idx_q*WORD_W +: WORD_W];
        end
    end

    assign req_ready = !busy;
    assign fl_rd     = busy;
    assign fl_line   = f_tag_q;

    p_off_never_fast_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode_active(mode_q)) |=> !rsp_valid);
    p_hit_next_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && hit_any) |=> rsp_valid);
    p_line_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fl_rd && !done) |=> (fl_rd && $stable(fl_line)));
    p_rsp_cause_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(accept) || $past(done)));
endmodule

// File: tb/flash_accel_bench.sv
module flash_accel_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1;
    logic         mode_we = 1'b0, tim_we = 1'b0;
    logic [1:0]   mode_wdata = '0;
    logic [3:0]   tim_wdata = '0;
    logic         req_valid = 1'b0, req_seq = 1'b0;
    logic         req_ready, rsp_valid, fl_rd;
    logic [15:0]  req_addr = '0;
    logic [31:0]  rsp_data;
    logic [13:0]  fl_line;
    logic [127:0] fl_rdata;

    flash_accel u_flash_accel (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tim_we(tim_we), .tim_wdata(tim_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_seq(req_seq),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_rd(fl_rd),
        .fl_line(fl_line), .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] fdat(logic [13:0] tag, logic [1:0] i);
        return {4'hA, 2'b01, tag, 10'h155, i};
    endfunction

    always_comb
        for (int i = 0; i < 4; i++) fl_rdata[i*32 +: 32] = fdat(fl_line, 2'(i));

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;
    typedef struct { logic [31:0] data; int unsigned due; string tag; } exp_t;
    exp_t sbq[$];

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_data, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
                check(cyc == e.due, {e.tag, " timing"}, cyc, e.due);
            end
        end
    end

    task automatic access(logic [15:0] a, bit seq, int lat, string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_seq = seq; req_valid = 1'b1;
        e.data = fdat(a[15:2], a[1:0]); e.due = cyc + lat; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic set_tim(logic [3:0] t);
        @(negedge clk);
        tim_we = 1'b1; tim_wdata = t;
        @(negedge clk);
        tim_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        check(fl_rd == 1'b0, "R1 fl_rd after reset", fl_rd, 0);

        // mode 0, wait count 0 -> 15 cycles
        access(16'h0010, 1'b0, 16, "R2 R8 mode0 zero-wait miss");
        access(16'h0011, 1'b1, 16, "R2 mode0 seq still fetches");
        access(16'h0013, 1'b1, 16, "R2 mode0 idx3 no prefetch");
        access(16'h0014, 1'b1, 16, "R2 mode0 next line fetches");

        set_mode(2'd0);
        set_tim(4'd3);
        set_mode(2'd1);
        access(16'h0020, 1'b0, 4, "R3 R8 mode1 nonseq miss");
        access(16'h0021, 1'b1, 1, "R3 mode1 seq hit");
        access(16'h0022, 1'b0, 4, "R3 mode1 nonseq refetch");
        access(16'h0023, 1'b1, 1, "R3 R5 mode1 seq hit idx3");
        access(16'h0024, 1'b1, 1, "R7 prefetched line hit");
        access(16'h0025, 1'b1, 1, "R7 R5 prefetched word1");

        set_mode(2'd2);
        access(16'h0024, 1'b1, 4, "R9 flush forces miss");
        access(16'h0040, 1'b0, 4, "R6 nonseq miss to trail");
        access(16'h0026, 1'b0, 1, "R4 R6 nonseq hit prefetch buf");
        access(16'h0041, 1'b1, 1, "R6 trail buf kept");
        access(16'h0043, 1'b1, 1, "R7 hit idx3 triggers prefetch");
        access(16'h0044, 1'b1, 1, "R7 next line hit");
        access(16'h0025, 1'b0, 4, "R6 evicted line misses");
        access(16'h0045, 1'b0, 1, "R4 nonseq hit");
        access(16'h005B, 1'b0, 4, "R7 miss idx3");
        access(16'h005C, 1'b1, 1, "R7 chained prefetch hit");
        access(16'h005A, 1'b1, 1, "R6 R5 trail buf word2");

        set_mode(2'd3);
        access(16'h005C, 1'b1, 4, "R2 R9 reserved mode acts off");
        access(16'h005D, 1'b1, 4, "R2 reserved mode no reuse");

        repeat (40) @(negedge clk);
        check(sbq.size() == 0, "R10 all responses seen", sbq.size(), 0);
        finish_run();
    end
endmodule